// File: doc/BRIEF.md
# Serial-to-Parallel Converter with Bit Slip

This block turns a serial bit stream into 4-bit parallel words. It runs from a single bit-rate clock. One of two serial inputs is selected as the source. The second input gives a loopback path for testing. Bits enter a shift register, and at each word boundary the register contents are copied to the parallel output. The first bit of a word lands on output bit 0. The block also drives three registered outputs: a divide-by-4 clock, a divide-by-8 clock and a retimed copy of the selected serial stream.

A mode input moves the parallel update from every fourth bit to every eighth bit. Two blocks can then share the work of an 8-bit conversion. An asynchronous sync input lets the receiver move the word boundary. Each sync assertion makes the internal bit counter skip one advance, which delays the boundary by one bit. The data then appears one output index lower. A synchronous reset clears the counter and all data registers.

Top module: `serpar_slip`

## Requirements
- R1: With `mode8` low, `par_q` is loaded once every 4 bit clocks. The first bit of each 4-bit word lands on `par_q[0]` and the fourth on `par_q[3]`. After reset, the first word is the bits sampled at the first four rising edges. Between loads, `par_q` holds its value.
- R2: With `mode8` high, `par_q` is loaded once every 8 bit clocks. It takes the 5th to 8th bits of each 8-bit group, with the 5th bit on `par_q[0]`. It stays zero through the first four bits after reset.
- R3: `sel_b` low selects `din_a` as the source, and `sel_b` high selects `din_b`. The unselected input has no effect on `par_q` or `sout`.
- R4: `sout` equals the selected serial input as sampled at the previous rising edge.
- R5: `clk_word` toggles every 2 bit clocks, and `clk_pair` toggles every 4 bit clocks. After reset, `clk_word` is high for the 3rd and 4th counts of each group of four, and `clk_pair` is high for counts 5 to 8 of each group of eight.
- R6: A `sync_in` assertion held for at least two bit clocks makes the bit counter hold for one clock. This happens at the third rising edge after `sync_in` rises. No load happens on that edge, every later word boundary is one bit later, and each word's data moves one index lower.
- R7: One `sync_in` assertion slips exactly one bit, however long it is held.
- R8: While `rst` is high at a rising edge, the counter, the shift register, `par_q` and `sout` clear to zero, and `clk_word` and `clk_pair` go low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din_a | input | 1 | Serial data input A |
| din_b | input | 1 | Serial data input B (loopback) |
| sel_b | input | 1 | Source select: 0 = A, 1 = B |
| mode8 | input | 1 | 0 = load every 4 bits, 1 = every 8 bits |
| sync_in | input | 1 | Asynchronous word-boundary slip request |
| par_q | output | 4 | Parallel word, bit 0 = earliest bit |
| sout | output | 1 | Retimed selected serial stream |
| clk_word | output | 1 | Divide-by-4 clock output |
| clk_pair | output | 1 | Divide-by-8 clock output |

## Verification
Each vector drives a different pattern on the two serial inputs, so an inverted select would load the wrong word. The vectors also cover both modes. A design that loaded on the wrong count, or reversed the bit order, would show the wrong word after the fourth or eighth bit. The slip test checks the exact edge on which the boundary moves, that no load happens on the swallowed edge, and the words that follow. An off-by-one in the synchronizer depth, or a slip that failed to freeze the counter, would put data one index away from the expected value. A long sync assertion is checked separately: a level-sensitive design would slip on every cycle of the hold and scramble every later word.

// File: rtl/serpar_pkg.sv
package serpar_pkg;

    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_e;

    function automatic logic pick_bit(input src_e src, input logic a, input logic b);
        return (src == SRC_B) ? b : a;
    endfunction

endpackage

// File: rtl/serpar_sync.sv
module serpar_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic pulse
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], async_in};
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // rising edge seen after the last synchronizing stage
    assign pulse = st_q.chain[STAGES-1] & ~st_q.chain[STAGES];

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse); // R7

endmodule

// File: rtl/serpar_divider.sv
module serpar_divider #(
    parameter int WORD_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic slip,
    input  logic mode8,
    output logic load,
    output logic div_word,
    output logic div_pair
);
    localparam int CNT_W = $clog2(2 * WORD_W);
    localparam int LOW_W = CNT_W - 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(2 * WORD_W - 1);
    localparam logic [LOW_W-1:0] WORD_MAX = LOW_W'(WORD_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!slip) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        if (mode8) begin
            load = !slip && (st_q.cnt == CNT_MAX);
        end else begin
            load = !slip && (st_q.cnt[LOW_W-1:0] == WORD_MAX);
        end
    end

    assign div_word = st_q.cnt[CNT_W-2];
    assign div_pair = st_q.cnt[CNT_W-1];

    AST_SWALLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        slip |=> (st_q.cnt == $past(st_q.cnt))); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !slip |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1))); // R5

endmodule

// File: rtl/serpar_shift.sv
module serpar_shift #(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              load,
    output logic [WORD_W-1:0] par,
    output logic              ser
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [WORD_W-1:0] par;
        logic              ser;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sr  = {bit_in, st_q.sr[WORD_W-1:1]};
        st_d.ser = bit_in;
        if (load) begin
            st_d.par = st_d.sr;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign par = st_q.par;
    assign ser = st_q.ser;

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(st_q.par)); // R1

endmodule

// File: rtl/serpar_slip.sv
module serpar_slip #(
    parameter int WORD_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din_a,
    input  logic              din_b,
    input  logic              sel_b,
    input  logic              mode8,
    input  logic              sync_in,
    output logic [WORD_W-1:0] par_q,
    output logic              sout,
    output logic              clk_word,
    output logic              clk_pair
);
    import serpar_pkg::*;

    logic bit_sel;
    logic slip;
    logic load;

    assign bit_sel = pick_bit(src_e'(sel_b), din_a, din_b);

    serpar_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sync_in),
        .pulse    (slip)
    );

    serpar_divider #(.WORD_W(WORD_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .slip     (slip),
        .mode8    (mode8),
        .load     (load),
        .div_word (clk_word),
        .div_pair (clk_pair)
    );

    serpar_shift #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .bit_in (bit_sel),
        .load   (load),
        .par    (par_q),
        .ser    (sout)
    );

    AST_SOUT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sout == $past(sel_b ? din_b : din_a))); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (par_q == '0 && !clk_word && !clk_pair && !sout)); // R8

endmodule

// File: tb/serpar_slip_tb.sv
module serpar_slip_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din_a = 1'b0;
    logic       din_b = 1'b0;
    logic       sel_b = 1'b0;
    logic       mode8 = 1'b0;
    logic       sync_in = 1'b0;
    logic [3:0] par_q;
    logic       sout;
    logic       clk_word;
    logic       clk_pair;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    serpar_slip u_dut (
        .clk      (clk),
        .rst      (rst),
        .din_a    (din_a),
        .din_b    (din_b),
        .sel_b    (sel_b),
        .mode8    (mode8),
        .sync_in  (sync_in),
        .par_q    (par_q),
        .sout     (sout),
        .clk_word (clk_word),
        .clk_pair (clk_pair)
    );

    // {sel_b, mode8, pattern_a[7:0], pattern_b[7:0]}, bit i sent at step i
    localparam logic [17:0] VEC [6] = '{
        {1'b0, 1'b0, 8'hA6, 8'h3C},
        {1'b1, 1'b0, 8'hA6, 8'h3C},
        {1'b0, 1'b1, 8'h5B, 8'hE1},
        {1'b1, 1'b1, 8'h5B, 8'hE1},
        {1'b0, 1'b0, 8'h81, 8'h7E},
        {1'b1, 1'b0, 8'h00, 8'hFF}
    };

    localparam logic [31:0] PAT = 32'hB4E1_5C93;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // one rising edge, then return at the falling edge
    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst     = 1'b1;
        sync_in = 1'b0;
        cycle();
        chk("R8 par_q", 8'(par_q), 8'h00);
        chk("R8 clk_word/clk_pair/sout", {5'b0, clk_word, clk_pair, sout}, 8'h00);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        repeat (2) cycle();

        // table walk: R1 R2 R3 R4 R5 R8
        foreach (VEC[v]) begin
            logic [7:0] pa, pb, ps;
            pa = VEC[v][15:8];
            pb = VEC[v][7:0];
            ps = VEC[v][17] ? pb : pa;
            do_reset();
            sel_b = VEC[v][17];
            mode8 = VEC[v][16];
            for (int i = 0; i < 8; i++) begin
                din_a = pa[i];
                din_b = pb[i];
                cycle();
                chk("R4 sout", 8'(sout), 8'(ps[i]));
                chk("R5 clk_word", 8'(clk_word), 8'(((i + 1) >> 1) & 1));
                chk("R5 clk_pair", 8'(clk_pair), 8'(((i + 1) >> 2) & 1));
                if (i == 3) begin
                    if (mode8) chk("R2 no load at 4", 8'(par_q), 8'h00);
                    else       chk("R1 R3 first word", 8'(par_q), 8'(ps[3:0]));
                end
                if (i == 7) chk("R1 R2 R3 word", 8'(par_q), 8'(ps[7:4]));
            end
        end

        // single slip: sync high for steps 9 and 10, swallow on edge 11
        do_reset();
        sel_b = 1'b0;
        mode8 = 1'b0;
        din_b = 1'b1;
        for (int n = 0; n < 21; n++) begin
            din_a   = PAT[n];
            sync_in = (n == 9 || n == 10);
            cycle();
            if (n == 7)  chk("R1 before slip", 8'(par_q), 8'(PAT[7:4]));
            if (n == 11) chk("R6 no load on swallow", 8'(par_q), 8'(PAT[7:4]));
            if (n == 11) chk("R6 clk_word held", 8'(clk_word), 8'h1);
            if (n == 12) chk("R6 shifted word", 8'(par_q), 8'(PAT[12:9]));
            if (n == 15) chk("R6 hold between", 8'(par_q), 8'(PAT[12:9]));
            if (n == 16) chk("R6 next word", 8'(par_q), 8'(PAT[16:13]));
            if (n == 20) chk("R6 later word", 8'(par_q), 8'(PAT[20:17]));
        end

        // long sync hold: high steps 1..8, exactly one swallow at edge 3
        do_reset();
        for (int n = 0; n < 17; n++) begin
            din_a   = PAT[n];
            sync_in = (n >= 1 && n <= 8);
            cycle();
            if (n == 3)  chk("R7 no load on swallow", 8'(par_q), 8'h00);
            if (n == 4)  chk("R7 first word", 8'(par_q), 8'(PAT[4:1]));
            if (n == 4)  chk("R7 clk_pair", {6'b0, clk_word, clk_pair}, 8'h01);
            if (n == 8)  chk("R7 second word", 8'(par_q), 8'(PAT[8:5]));
            if (n == 12) chk("R7 third word", 8'(par_q), 8'(PAT[12:9]));
            if (n == 16) chk("R7 fourth word", 8'(par_q), 8'(PAT[16:13]));
        end

        // reset in mid stream after data loaded
        sync_in = 1'b0;
        do_reset();

        finish_run();
    end

endmodule